// File: doc/BRIEF.md
# Register-Based LIFO Stack with Full and Empty Flags

This block is a last-in, first-out store built from flip-flops. A pointer register selects one of the word slots. A push advances the pointer first and then writes the incoming word into the slot it now selects. A pop copies the slot under the pointer into a registered data output and then steps the pointer back. The pointer is a plain modular counter. The two status flags do not come from a separate occupancy count. They follow from the moment the pointer lands on zero: after a push, that means the stack has wrapped and is full; after a pop, it means the stack is drained and empty. As a result, the first word pushed goes into slot 1, and slot 0 receives the final word that fills the stack.

A push request while the stack is full is dropped and reported with a one-cycle overflow pulse. A pop request while it is empty is dropped and reported with a one-cycle underflow pulse. If push and pop are requested in the same cycle, the stack does nothing. The data output keeps its value until the next pop that succeeds.

Top module: `lifo_regstack`

## Requirements
- R1: After a synchronous reset the empty flag is 1, the full flag is 0, the data output is 0 and both pulse outputs are 0.
- R2: An accepted push increments the pointer and then stores the input word in the slot the pointer now selects. The first push after reset therefore writes slot 1.
- R3: An accepted pop loads the word under the pointer into the data output on the next clock edge and then decrements the pointer. In every other cycle the data output keeps its value.
- R4: A push that moves the pointer to zero sets the full flag. With the default 6-bit pointer this is the 64th push into an empty stack. Every accepted push clears the empty flag.
- R5: A pop that moves the pointer to zero sets the empty flag. Every accepted pop clears the full flag.
- R6: A push request while full is 1 changes neither the pointer nor the contents. One cycle later the overflow output is 1 for exactly one cycle.
- R7: A pop request while empty is 1 changes neither the pointer nor the data output. One cycle later the underflow output is 1 for exactly one cycle.
- R8: When push and pop are both 1 in the same cycle, the pointer, the flags, the contents and the data output stay unchanged, and neither pulse output is raised.
- R9: Slot 0 holds the last word pushed into a full stack. Popping a full stack returns that word first and leaves both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din_i | input | DATA_W | Word to push |
| dout_o | output | DATA_W | Registered word from the last accepted pop |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| ovf_o | output | 1 | One-cycle pulse after a rejected push |
| udf_o | output | 1 | One-cycle pulse after a rejected pop |

## Verification
Push and pop can both be requested in the same cycle, and the block must then leave every piece of state alone. The bench provokes this in three states: on an empty stack, on a partly filled stack and on a full stack. It also mixes random push and pop requests, where collisions occur often. In each such cycle the behavioural queue model predicts no change and no pulse, and any difference is reported against R8. Collisions on a full or an empty stack matter most, because a rejected single request would raise a pulse there, while a collision must not.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;

    typedef enum logic [2:0] {
        STK_IDLE,
        STK_PUSH,
        STK_POP,
        STK_OVF,
        STK_UDF
    } stk_op_e;

    // Resolve the request pair against the current flags into one action.
    function automatic stk_op_e stk_decode(
        input logic push,
        input logic pop,
        input logic full,
        input logic empty
    );
        stk_op_e op;
        op = STK_IDLE;
        if (push && !pop) begin
            op = full ? STK_OVF : STK_PUSH;
        end else if (pop && !push) begin
            op = empty ? STK_UDF : STK_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/lifo_stack_ptr.sv
module lifo_stack_ptr
    import lifo_stack_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o,
    output logic             udf_o
);
    localparam logic [PTR_W-1:0] SP_TOP = '1;

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;

    assign sp_inc = sp_q + 1'b1;
    assign sp_dec = sp_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            full_o  <= 1'b0;
            empty_o <= 1'b1;
            ovf_o   <= 1'b0;
            udf_o   <= 1'b0;
        end else begin
            ovf_o <= (op_i == STK_OVF);
            udf_o <= (op_i == STK_UDF);
            case (op_i)
                STK_PUSH: begin
                    sp_q    <= sp_inc;
                    full_o  <= (sp_inc == '0);
                    empty_o <= 1'b0;
                end
                STK_POP: begin
                    sp_q    <= sp_dec;
                    empty_o <= (sp_dec == '0);
                    full_o  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign sp_o     = sp_q;
    assign wr_idx_o = sp_inc;

    // R4: wrapping push raises full
    a_r4_full_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH && sp_q == SP_TOP) |=> (full_o && !empty_o));
    // R5: pop down to zero raises empty
    a_r5_empty_on_drain: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_POP && sp_q == PTR_W'(1)) |=> (empty_o && !full_o));
    // R6: rejected push keeps the pointer and pulses overflow
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_OVF) |=> (ovf_o && sp_q == $past(sp_q)));
    // R7: rejected pop keeps the pointer and pulses underflow
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_UDF) |=> (udf_o && sp_q == $past(sp_q)));
    // R1: flags never both set
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

endmodule

// File: rtl/lifo_stack_bank.sv
module lifo_stack_bank #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (we_i && waddr_i == PTR_W'(g)) begin
                slot_q <= wdata_i;
            end
        end
        assign rows[g] = slot_q;
    end

    assign rdata_o = rows[raddr_i];

    // R2: a write lands in the addressed slot
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (rows[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
    import lifo_stack_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              ovf_o,
    output logic              udf_o
);
    stk_op_e           op;
    logic [PTR_W-1:0]  sp;
    logic [PTR_W-1:0]  wr_idx;
    logic [DATA_W-1:0] top_word;

    assign op = stk_decode(push_i, pop_i, full_o, empty_o);

    lifo_stack_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .sp_o     (sp),
        .wr_idx_o (wr_idx),
        .full_o   (full_o),
        .empty_o  (empty_o),
        .ovf_o    (ovf_o),
        .udf_o    (udf_o)
    );

    lifo_stack_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (op == STK_PUSH),
        .waddr_i (wr_idx),
        .wdata_i (din_i),
        .raddr_i (sp),
        .rdata_o (top_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= '0;
        end else if (op == STK_POP) begin
            dout_o <= top_word;
        end
    end

    // R8: simultaneous requests do nothing
    a_r8_collision_idle: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> (!ovf_o && !udf_o && $stable(dout_o)
                               && $stable(full_o) && $stable(empty_o)));
    // R3: output holds without a pop request
    a_r3_dout_holds: assert property (@(posedge clk) disable iff (rst)
        !pop_i |=> $stable(dout_o));

endmodule

// File: tb/sim_lifo_regstack.sv
module sim_lifo_regstack;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full, empty, ovf, udf;

    int n_checks = 0;
    int n_fails = 0;

    // reference model
    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_dout = '0;
    logic [DW-1:0] last_pushed = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lifo_regstack #(.DATA_W(DW), .PTR_W(6)) u0 (
        .clk(clk), .rst(rst), .push_i(push), .pop_i(pop), .din_i(din),
        .dout_o(dout), .full_o(full), .empty_o(empty), .ovf_o(ovf), .udf_o(udf)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
        logic e_ovf, e_udf, both;
        e_ovf = 1'b0;
        e_udf = 1'b0;
        both  = p && q;
        push = p; pop = q; din = d;
        if (p && !q) begin
            if (mq.size() == DEPTH) e_ovf = 1'b1;
            else begin mq.push_back(d); last_pushed = d; end
        end else if (q && !p) begin
            if (mq.size() == 0) e_udf = 1'b1;
            else m_dout = mq.pop_back();
        end
        @(posedge clk);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        check(dout == m_dout, both ? "R8" : "R3", "dout", dout, m_dout);
        check(full == (mq.size() == DEPTH), both ? "R8" : "R4", "full",
              full, mq.size() == DEPTH);
        check(empty == (mq.size() == 0), both ? "R8" : "R5", "empty",
              empty, mq.size() == 0);
        check(ovf == e_ovf, both ? "R8" : "R6", "ovf", ovf, e_ovf);
        check(udf == e_udf, both ? "R8" : "R7", "udf", udf, e_udf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(empty == 1'b1, "R1", "empty", empty, 1);
        check(full == 1'b0, "R1", "full", full, 0);
        check(dout == '0, "R1", "dout", dout, 0);
        check(ovf == 1'b0 && udf == 1'b0, "R1", "pulses", {ovf, udf}, 0);

        // R7 pop on empty, then idle cycle: pulse must drop
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        // R8 collision on empty
        step(1'b1, 1'b1, 8'h55);

        // R2 LIFO order of a short run
        step(1'b1, 1'b0, 8'h11);
        step(1'b1, 1'b0, 8'h22);
        step(1'b1, 1'b0, 8'h33);
        step(1'b1, 1'b1, 8'h44);   // R8 collision partly filled
        step(1'b0, 1'b1, 8'h00);
        check(dout == 8'h33, "R2", "top after pushes", dout, 8'h33);
        step(1'b0, 1'b0, 8'h00);
        check(dout == 8'h33, "R3", "hold", dout, 8'h33);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        check(dout == 8'h11 && empty, "R5", "drain", dout, 8'h11);

        // R4 fill to wrap
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(i * 7 + 3));
        check(full == 1'b1, "R4", "full after 64", full, 1);
        // R6 push while full, then idle
        step(1'b1, 1'b0, 8'hEE);
        step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'hEE);   // R8 collision full
        // R9 slot 0 returned first
        step(1'b0, 1'b1, 8'h00);
        check(dout == last_pushed, "R9", "first pop of full", dout, last_pushed);
        check(!full && !empty, "R9", "flags after pop", {full, empty}, 0);
        step(1'b1, 1'b0, 8'hA5);
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00);
        check(empty == 1'b1, "R5", "empty after drain", empty, 1);

        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] r;
            r = 2'($urandom_range(0, 3));
            step(r[0], r[1], DW'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule